// File: doc/BRIEF.md
# Row Scan and Grayscale Pulse Generator

This block sets the row-by-row timing of a common-cathode matrix display. It also turns each pixel's colour components into drive pulses. A sequencer walks through the active scan positions, one row period at a time. For each position it works out two things: which frame-memory row to show, and which common line to drive. The frame memory returns one whole row of 16-bit pixels on a combinational read port. Each pixel is split into three components, and each component becomes a 6-bit gray level. A pulse-width table then turns the level into a width, measured in row-period steps.

The table holds widths for the odd levels only. Each even level takes the mean of its two odd neighbours. Global display modes can override the memory contents, and a display-off setting stops all drive. The configuration arrives as static inputs. The table is written through a single-entry write port.

Top module: `rowscan_pwm`

## Requirements
- R1: While `rst_n` is low, all outputs are zero after a clock edge. On the first edge after release, `row_strobe` and `frame_start` are 1 and scanning restarts at position 0. After reset, table entry k holds width 4k+1, so the widths run 1, 5, … 125.
- R2: Every D clocks form one step, where D = `cfg_div`+1. A row lasts D·K clocks, where K = `cfg_row_len` and values below 2 count as 2. A frame has N rows, where N = `cfg_mux`+1 and values of `cfg_mux` below 15 give N = 16. `row_strobe` is high for the first clock of each row only, and `frame_start` is high only on the strobe of scan position 0.
- R3: During scan position s, `mem_rd_addr` = (`cfg_start` + s) mod 64.
- R4: `row_idx` for position s is computed in three steps. First, g = s, or g = N−1−s when `cfg_rev` is 1. Next, h = (g + `cfg_offset`) mod 64. Finally, `row_idx` = h when `cfg_split` is 0; when `cfg_split` is 1 it is 2h for h < 32 and 2(h−32)+1 otherwise.
- R5: Level 0 produces no pulse. An odd level L uses table entry (L−1)/2.
- R6: An even level L ≥ 2 uses floor((entry L/2−1 + entry L/2)/2).
- R7: In each row, a channel with width w is high for D·min(w,K) clocks, counted from the row's strobe clock.
- R8: `cfg_mode` selects the display mode: 0 shows the memory contents, 1 forces level 63, 2 forces level 0, and 3 shows 63 minus the memory level.
- R9: When `cfg_on` is 0, `drive_en` is 0 and every `col_pulse` bit is 0, starting from the next clock.
- R10: A table write stores `tbl_wdata`, limited to 125, into entry `tbl_addr`. It takes effect on the next clock.
- R11: Pixel p sits at `mem_rd_data[16p+15:16p]` and drives channel 3p+c. Component c=0 is bits [4:0], c=1 is bits [10:5] and c=2 is bits [15:11]. A 5-bit component v becomes the level {v, v[4]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_on | input | 1 | Display on |
| cfg_mode | input | 2 | Display mode select |
| cfg_mux | input | 6 | Scanned rows minus one |
| cfg_start | input | 6 | Memory row shown at scan position 0 |
| cfg_offset | input | 6 | Common index shift |
| cfg_rev | input | 1 | Reverse scan direction |
| cfg_split | input | 1 | Interleave commons between even and odd lines |
| cfg_row_len | input | 8 | Steps per row period (K) |
| cfg_div | input | 4 | Clocks per step minus one |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table entry (odd level index) |
| tbl_wdata | input | 8 | Width to store |
| mem_rd_addr | output | 6 | Frame-memory row address |
| mem_rd_data | input | NPIX*16 | Pixel row returned for `mem_rd_addr` |
| row_idx | output | 6 | Common line being driven |
| row_strobe | output | 1 | First clock of a row |
| frame_start | output | 1 | First clock of a frame |
| drive_en | output | 1 | Row and column drivers enabled |
| col_pulse | output | 3*NPIX | Per-channel drive pulses |

## Verification
The outputs `row_idx`, the strobes, `drive_en` and `col_pulse` are registered. Each one shows the sequencer state of the previous clock. `mem_rd_addr` follows the current state directly.

The bench samples on falling edges and first waits for a `frame_start`. At each strobe it checks the row index and the memory address. It then counts the high clocks of every channel over exactly D·K samples, beginning with the strobe sample. The next sample must be the following row's strobe. Configuration, memory and table changes are applied before that synchronisation, so every measured row reflects the new settings.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    // Display mode encodings shared by the channel logic.
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_ALL_ON  = 2'd1,
        MODE_ALL_OFF = 2'd2,
        MODE_INVERSE = 2'd3
    } disp_mode_e;

    localparam int LVL_W = 6;
    localparam int PIX_W = 16;
    localparam int WID_W = 7;
    localparam int TBL_N = 32;
    localparam int STEP_W = 8;
    localparam logic [WID_W-1:0] MAX_WID = 7'd125;
    localparam logic [LVL_W-1:0] TOP_LVL = 6'd63;

    // Widen a 5-bit component to a 6-bit level by repeating its top bit.
    function automatic logic [LVL_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4]};
    endfunction
endpackage

// File: rtl/rsp_seq.sv
// Row sequencer: step prescaler, step counter within a row and scan position.
// It derives the memory row address and the common index from the position.
// Assumes ROWS is a power of two, so the address and offset sums wrap by truncation.
module rsp_seq
    import rsp_pkg::*;
#(
    parameter int ROWS    = 64,
    parameter int MIN_MUX = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(ROWS)-1:0] cfg_mux,
    input  logic [$clog2(ROWS)-1:0] cfg_start,
    input  logic [$clog2(ROWS)-1:0] cfg_offset,
    input  logic                    cfg_rev,
    input  logic                    cfg_split,
    input  logic [STEP_W-1:0]       cfg_row_len,
    input  logic [3:0]              cfg_div,
    output logic [$clog2(ROWS)-1:0] mem_addr,
    output logic [$clog2(ROWS)-1:0] com_idx,
    output logic [STEP_W-1:0]       dot,
    output logic                    row_first,
    output logic                    frame_first
);
    localparam int RW = $clog2(ROWS);

    logic [RW-1:0]     scan_q;
    logic [STEP_W-1:0] dot_q;
    logic [3:0]        sub_q;
    logic [RW-1:0]     last_scan;
    logic [STEP_W-1:0] last_dot;
    logic              tick;
    logic              row_end;
    logic [RW-1:0]     logical;
    logic [RW-1:0]     shifted;

    // Clamp the limits and decode the end of a step and the end of a row.
    always_comb begin
        last_scan = (cfg_mux < RW'(MIN_MUX - 1)) ? RW'(MIN_MUX - 1) : cfg_mux;
        last_dot  = (cfg_row_len < STEP_W'(2)) ? STEP_W'(1) : cfg_row_len - STEP_W'(1);
        tick      = (sub_q >= cfg_div);
        row_end   = tick && (dot_q >= last_dot);
    end

    // Advance the prescaler, then the step counter, then the scan position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q <= '0;
            dot_q  <= '0;
            sub_q  <= '0;
        end else if (tick) begin
            sub_q <= '0;
            if (row_end) begin
                dot_q  <= '0;
                scan_q <= (scan_q >= last_scan) ? '0 : scan_q + RW'(1);
            end else begin
                dot_q <= dot_q + STEP_W'(1);
            end
        end else begin
            sub_q <= sub_q + 4'd1;
        end
    end

    // Map the scan position to a memory row and a common line; split is a bit rotation.
    always_comb begin
        logical     = cfg_rev ? (last_scan - scan_q) : scan_q;
        shifted     = logical + cfg_offset;
        com_idx     = cfg_split ? {shifted[RW-2:0], shifted[RW-1]} : shifted;
        mem_addr    = cfg_start + scan_q;
        dot         = dot_q;
        row_first   = (dot_q == '0) && (sub_q == '0);
        frame_first = row_first && (scan_q == '0);
    end

    // R2: at a row end the position either wraps to zero or moves up by one.
    a_r2_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |=> (scan_q == '0) || (scan_q == RW'($past(scan_q) + 1)));
    // R2: between steps neither the step counter nor the position moves.
    a_r2_dot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(dot_q) && $stable(scan_q)));
endmodule

// File: rtl/rsp_gtab.sv
// Odd-level pulse-width table: TBL_N entries with one write port.
// Writes are limited to the maximum width; reset loads the linear ramp 4k+1.
module rsp_gtab
    import rsp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [4:0]               addr,
    input  logic [7:0]               wdata,
    output logic [TBL_N*WID_W-1:0]   tbl_flat
);
    logic [WID_W-1:0] ent_q [TBL_N];

    // Hold the widths; load the ramp at reset and a limited value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TBL_N; k++) begin
                ent_q[k] <= WID_W'(4 * k + 1);
            end
        end else if (we) begin
            ent_q[addr] <= (wdata > {1'b0, MAX_WID}) ? MAX_WID : wdata[WID_W-1:0];
        end
    end

    // Flatten the entries for the per-channel lookups.
    for (genvar k = 0; k < TBL_N; k++) begin : g_flat
        assign tbl_flat[k*WID_W +: WID_W] = ent_q[k];
    end

    // R10: a written entry never holds more than the maximum width.
    a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ent_q[$past(addr)] <= MAX_WID));
endmodule

// File: rtl/rsp_chan.sv
// One drive channel: applies the display mode to a level, looks up or
// interpolates its width, and compares the width with the row step counter.
// Assumes the step counter restarts from zero at every row.
module rsp_chan
    import rsp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   on,
    input  logic [1:0]             mode,
    input  logic [LVL_W-1:0]       lvl_raw,
    input  logic [STEP_W-1:0]      dot,
    input  logic [TBL_N*WID_W-1:0] tbl_flat,
    output logic                   pulse_o
);
    logic [LVL_W-1:0] lvl;
    logic [4:0]       hi_idx;
    logic [4:0]       lo_idx;
    logic [WID_W-1:0] w_hi;
    logic [WID_W-1:0] w_lo;
    logic [WID_W:0]   w_sum;
    logic [WID_W-1:0] width;

    // Apply the global display mode to the memory level.
    always_comb begin
        unique case (disp_mode_e'(mode))
            MODE_ALL_ON:  lvl = TOP_LVL;
            MODE_ALL_OFF: lvl = '0;
            MODE_INVERSE: lvl = TOP_LVL - lvl_raw;
            default:      lvl = lvl_raw;
        endcase
    end

    // Odd levels read one entry; even levels average the entries on each side.
    always_comb begin
        hi_idx = lvl[LVL_W-1:1];
        lo_idx = hi_idx - 5'd1;
        w_hi   = tbl_flat[int'(hi_idx)*WID_W +: WID_W];
        w_lo   = tbl_flat[int'(lo_idx)*WID_W +: WID_W];
        w_sum  = {1'b0, w_lo} + {1'b0, w_hi};
        if (lvl == '0)      width = '0;
        else if (lvl[0])    width = w_hi;
        else                width = w_sum[WID_W:1];
    end

    // Register the pulse: high while the step counter is below the width.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= on && ({1'b0, width} > dot);
    end

    // R9: a disabled display gives no pulse on the next clock.
    a_r9_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> !pulse_o);
    // R5: level zero never drives.
    a_r5_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == '0) |=> !pulse_o);
    // R8: the all-off mode never drives.
    a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ALL_OFF) |=> !pulse_o);
endmodule

// File: rtl/rowscan_pwm.sv
// Top: row sequencer, pulse-width table and 3*NPIX drive channels.
// The frame memory is read combinationally; all display outputs are
// registered and show the sequencer state of the previous clock.
module rowscan_pwm
    import rsp_pkg::*;
#(
    parameter int NPIX = 4,
    parameter int ROWS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_on,
    input  logic [1:0]              cfg_mode,
    input  logic [$clog2(ROWS)-1:0] cfg_mux,
    input  logic [$clog2(ROWS)-1:0] cfg_start,
    input  logic [$clog2(ROWS)-1:0] cfg_offset,
    input  logic                    cfg_rev,
    input  logic                    cfg_split,
    input  logic [7:0]              cfg_row_len,
    input  logic [3:0]              cfg_div,
    input  logic                    tbl_we,
    input  logic [4:0]              tbl_addr,
    input  logic [7:0]              tbl_wdata,
    output logic [$clog2(ROWS)-1:0] mem_rd_addr,
    input  logic [NPIX*16-1:0]      mem_rd_data,
    output logic [$clog2(ROWS)-1:0] row_idx,
    output logic                    row_strobe,
    output logic                    frame_start,
    output logic                    drive_en,
    output logic [3*NPIX-1:0]       col_pulse
);
    localparam int RW  = $clog2(ROWS);
    localparam int NCH = 3 * NPIX;

    logic [RW-1:0]          com_idx;
    logic [STEP_W-1:0]      dot;
    logic                   row_first;
    logic                   frame_first;
    logic [TBL_N*WID_W-1:0] tbl_flat;

    rsp_seq #(.ROWS(ROWS), .MIN_MUX(16)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mux     (cfg_mux),
        .cfg_start   (cfg_start),
        .cfg_offset  (cfg_offset),
        .cfg_rev     (cfg_rev),
        .cfg_split   (cfg_split),
        .cfg_row_len (cfg_row_len),
        .cfg_div     (cfg_div),
        .mem_addr    (mem_rd_addr),
        .com_idx     (com_idx),
        .dot         (dot),
        .row_first   (row_first),
        .frame_first (frame_first)
    );

    rsp_gtab gtab_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tbl_we),
        .addr     (tbl_addr),
        .wdata    (tbl_wdata),
        .tbl_flat (tbl_flat)
    );

    // One channel per colour component of each pixel.
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        logic [PIX_W-1:0] pix;
        assign pix = mem_rd_data[p*PIX_W +: PIX_W];
        for (genvar c = 0; c < 3; c++) begin : g_comp
            logic [LVL_W-1:0] raw;
            if (c == 0) begin : g_a
                assign raw = widen5(pix[4:0]);
            end else if (c == 1) begin : g_b
                assign raw = pix[10:5];
            end else begin : g_c
                assign raw = widen5(pix[15:11]);
            end
            rsp_chan chan_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .on       (cfg_on),
                .mode     (cfg_mode),
                .lvl_raw  (raw),
                .dot      (dot),
                .tbl_flat (tbl_flat),
                .pulse_o  (col_pulse[3*p+c])
            );
        end
    end

    // Register the row index, the strobes and the driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx     <= '0;
            row_strobe  <= 1'b0;
            frame_start <= 1'b0;
            drive_en    <= 1'b0;
        end else begin
            row_idx     <= com_idx;
            row_strobe  <= row_first;
            frame_start <= frame_first;
            drive_en    <= cfg_on;
        end
    end

    // R2: a frame start is always also a row start.
    a_r2_frame_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> row_strobe);
    // R9: no column pulse while the drivers are disabled.
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (col_pulse == '0));
    // R1: the step counter is idle in the cycle after reset.
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && rst_n) |-> row_first);
    localparam int CHECK_NCH = NCH;
endmodule

// File: tb/rowscan_pwm_tb.sv
module rowscan_pwm_tb_top;
    localparam int NPIX = 4;
    localparam int NCH  = 3 * NPIX;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              cfg_on;
    logic [1:0]        cfg_mode;
    logic [5:0]        cfg_mux, cfg_start, cfg_offset;
    logic              cfg_rev, cfg_split;
    logic [7:0]        cfg_row_len;
    logic [3:0]        cfg_div;
    logic              tbl_we;
    logic [4:0]        tbl_addr;
    logic [7:0]        tbl_wdata;
    logic [5:0]        mem_rd_addr;
    logic [NPIX*16-1:0] mem_rd_data;
    logic [5:0]        row_idx;
    logic              row_strobe, frame_start, drive_en;
    logic [NCH-1:0]    col_pulse;

    logic [NPIX*16-1:0] mem [64];
    int tb_tbl [32];
    int n_chk = 0;
    int n_fail = 0;

    assign mem_rd_data = mem[mem_rd_addr];

    rowscan_pwm #(.NPIX(NPIX), .ROWS(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .cfg_mode(cfg_mode),
        .cfg_mux(cfg_mux), .cfg_start(cfg_start), .cfg_offset(cfg_offset),
        .cfg_rev(cfg_rev), .cfg_split(cfg_split), .cfg_row_len(cfg_row_len),
        .cfg_div(cfg_div), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .row_idx(row_idx), .row_strobe(row_strobe),
        .frame_start(frame_start), .drive_en(drive_en), .col_pulse(col_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_rows();
        return (cfg_mux < 15) ? 16 : int'(cfg_mux) + 1;
    endfunction

    function automatic int exp_com(input int s);
        int g = cfg_rev ? eff_rows() - 1 - s : s;
        int h = (g + int'(cfg_offset)) % 64;
        if (cfg_split) return (h < 32) ? 2 * h : 2 * (h - 32) + 1;
        return h;
    endfunction

    function automatic int exp_lvl(input logic [15:0] p, input int comp);
        int raw;
        if (comp == 0)      raw = {p[4:0], p[4]};
        else if (comp == 1) raw = int'(p[10:5]);
        else                raw = {p[15:11], p[15]};
        case (cfg_mode)
            2'd1:    return 63;
            2'd2:    return 0;
            2'd3:    return 63 - raw;
            default: return raw;
        endcase
    endfunction

    function automatic int exp_wid(input int l);
        if (l == 0) return 0;
        if (l % 2 == 1) return tb_tbl[(l - 1) / 2];
        return (tb_tbl[l / 2 - 1] + tb_tbl[l / 2]) / 2;
    endfunction

    task automatic write_tbl(input int idx, input int val);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 5'(idx); tbl_wdata = 8'(val);
        @(negedge clk);
        tbl_we = 1'b0;
        tb_tbl[idx] = (val > 125) ? 125 : val;
    endtask

    task automatic fill_mem();
        for (int a = 0; a < 64; a++) begin
            for (int p = 0; p < NPIX; p++) mem[a][16*p +: 16] = 16'($urandom);
        end
    endtask

    // Measure one full frame: row index, memory row and per-channel high counts.
    task automatic measure_frame(input string tag);
        int n = eff_rows();
        int k = (cfg_row_len < 2) ? 2 : int'(cfg_row_len);
        int d = int'(cfg_div) + 1;
        int cnt [NCH];
        @(negedge clk);
        while (!frame_start) @(negedge clk);
        for (int r = 0; r < n; r++) begin
            chk("R2 row strobe", int'(row_strobe), 1);
            chk("R2 frame start", int'(frame_start), (r == 0) ? 1 : 0);
            chk("R4 common index", int'(row_idx), exp_com(r));
            chk("R3 memory row", int'(mem_rd_addr), (int'(cfg_start) + r) % 64);
            chk("R9 drive enable", int'(drive_en), int'(cfg_on));
            for (int c = 0; c < NCH; c++) cnt[c] = 0;
            for (int t = 0; t < d * k; t++) begin
                if (t > 0) @(negedge clk);
                if (t == 1) chk("R2 strobe one clock", int'(row_strobe), 0);
                for (int c = 0; c < NCH; c++) cnt[c] += int'(col_pulse[c]);
            end
            for (int c = 0; c < NCH; c++) begin
                logic [15:0] px = mem[(int'(cfg_start) + r) % 64][16*(c/3) +: 16];
                int w = cfg_on ? exp_wid(exp_lvl(px, c % 3)) : 0;
                chk(tag, cnt[c], d * ((w < k) ? w : k));
            end
            @(negedge clk);
        end
        chk("R2 frame length", int'(frame_start), 1);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1d2c);
        for (int k = 0; k < 32; k++) tb_tbl[k] = 4 * k + 1;
        rst_n = 1'b0; cfg_on = 1'b0; cfg_mode = 2'd0; cfg_mux = 6'd63;
        cfg_start = '0; cfg_offset = '0; cfg_rev = 1'b0; cfg_split = 1'b0;
        cfg_row_len = 8'd125; cfg_div = 4'd0;
        tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
        fill_mem();

        // R1: outputs are zero in reset, then restart at scan position 0.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset drive_en", int'(drive_en), 0);
        chk("R1 reset pulses", int'(col_pulse), 0);
        chk("R1 reset strobes", int'({row_strobe, frame_start}), 0);
        chk("R1 reset row", int'(row_idx), 0);
        cfg_on = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first row strobe", int'(row_strobe), 1);
        chk("R1 first frame start", int'(frame_start), 1);
        chk("R1 first row index", int'(row_idx), 0);

        // R5 R6 R7 R11 with the reset table (R1) and crafted corner levels.
        cfg_mux = 6'd15; cfg_row_len = 8'd130;
        mem[0] = {16'hFFFF, 16'h0000, 16'h0020, 16'h0001};
        mem[1] = {5'd16, 6'd62, 5'd17, 5'd31, 6'd2, 5'd1, 16'h8410, 16'h07E0};
        measure_frame("R1 R5 R6 R7 R11 reset table widths");

        // R8: forced and inverted modes.
        cfg_mode = 2'd1; measure_frame("R8 all on");
        cfg_mode = 2'd2; measure_frame("R8 all off");
        cfg_mode = 2'd3; measure_frame("R8 inverse");
        cfg_mode = 2'd0;

        // R9: display off.
        cfg_on = 1'b0; cfg_row_len = 8'd6; measure_frame("R9 display off");
        cfg_on = 1'b1;

        // R10 R6: writes, the limit, and interpolation with edited entries.
        write_tbl(31, 200);
        write_tbl(0, 0);
        write_tbl(5, 3);
        write_tbl(6, 100);
        cfg_row_len = 8'd130;
        mem[2] = {5'd31, 6'd63, 5'd0, 6'd12, 5'd0, 5'd0, 6'd13, 5'd0,
                  6'd62, 6'd2, 4'd0, 16'h0000};
        cfg_start = 6'd62;
        measure_frame("R10 R6 programmed widths");
        cfg_start = '0;

        // R2 R4: reversed, split, offset rows with a slow step.
        cfg_rev = 1'b1; cfg_split = 1'b1; cfg_offset = 6'd27;
        cfg_mux = 6'd19; cfg_row_len = 8'd4; cfg_div = 4'd2;
        measure_frame("R2 R4 R7 reverse split offset");

        // R2: ratio below the minimum and shortest row.
        cfg_rev = 1'b0; cfg_split = 1'b0; cfg_offset = '0;
        cfg_mux = 6'd3; cfg_row_len = 8'd0; cfg_div = 4'd0;
        measure_frame("R2 R7 clamped ratio and row");

        // Random configurations.
        for (int it = 0; it < 10; it++) begin
            for (int j = 0; j < 3; j++) write_tbl($urandom_range(0, 31), $urandom_range(0, 255));
            fill_mem();
            cfg_mux = 6'($urandom_range(0, 63));
            cfg_start = 6'($urandom); cfg_offset = 6'($urandom);
            cfg_rev = 1'($urandom); cfg_split = 1'($urandom);
            cfg_row_len = 8'($urandom_range(0, 24));
            cfg_div = 4'($urandom_range(0, 1));
            cfg_mode = 2'($urandom);
            cfg_on = ($urandom % 5) != 0;
            measure_frame("R3 R4 R7 R8 R10 random");
        end

        summary();
        $finish;
    end
endmodule